// File: doc/BRIEF.md
# CAN Transmit Buffer Control

This block holds the control and status state of three CAN transmit buffers and drives an active-low interrupt line. Each buffer has a pending-request bit, a 2-bit priority and three failure flags: aborted, arbitration lost and transmit error. A request can be raised in three ways: a control-register write, a request-to-send command carrying a buffer mask, or a falling edge on that buffer's active-low request pin. The pin passes through a two-flop synchronizer before its edge is detected.

A separate transmit engine, which is not part of this block, reads the selected buffer (`nextValid`/`nextBuf`). It starts an attempt with `txStart` and reports how the attempt ended with `evtValid`/`evtKind`. The block updates the request bit, the flags and the interrupt flags from that result. In one-shot mode a failed attempt still sets its failure flag, but the request is dropped so the buffer gets no second attempt. An abort strobe withdraws every pending buffer that is not currently being sent.

Top module: `can_tx_buf_ctrl`

## Requirements
- R1: After reset all request bits, priorities, failure flags, transmit interrupt flags and the message-error flag are 0, `intN` is 1 and `nextValid` is 0.
- R2: A write (`regWrEn`) to buffer `regWrBuf` loads the priority from data bits [1:0] and sets the request when data bit 3 is 1. Other data bits are ignored. A write to a buffer whose request is already set is ignored as a whole.
- R3: A `rtsEn` strobe sets the request of every buffer whose bit is 1 in `rtsMask` (bit i = buffer i).
- R4: Buffer i's request sets on a falling edge of `reqPinN[i]`. It becomes visible after the third rising clock edge that follows the pin going low. A pin held low does not set the request again.
- R5: Setting a request clears that buffer's aborted, arbitration-lost and transmit-error flags.
- R6: `nextValid` is 1 when any request is set. `nextBuf` names the pending buffer with the highest priority value (3 is highest). On a tie, the higher buffer number wins.
- R7: `txStart` marks `nextBuf` as in flight. It is ignored while a buffer is in flight, when nothing is pending, or when `abortIn` is high in the same cycle. While a buffer is in flight, requests and writes aimed at it are ignored. Any `evtValid` ends the attempt.
- R8: `evtKind` 0 (success) clears the in-flight buffer's request and sets its transmit interrupt flag.
- R9: `evtKind` 1 (error after start) sets the buffer's transmit-error flag and the global message-error flag. The request stays set when one-shot mode is off.
- R10: `evtKind` 2 (arbitration lost) sets the buffer's arbitration-lost flag. The request stays set when one-shot mode is off. `evtKind` 3 changes no bit.
- R11: With `oneShot` high, an error or arbitration loss still sets its flag, but the request bit is cleared.
- R12: `abortIn` clears the request and sets the aborted flag of every pending buffer that is not in flight. The in-flight buffer is left untouched.
- R13: `intN` is low exactly when some interrupt flag and its enable are both 1. `intEn`/`flagClrMask` bit i covers buffer i's transmit flag and bit 3 covers the message-error flag. The flags stay set until a `flagClrEn` write with 1 in the matching mask bit clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control-register write strobe |
| regWrBuf | input | 2 | Buffer addressed by the write |
| regWrData | input | 8 | Write data: bit 3 request, bits 1:0 priority |
| rtsEn | input | 1 | Request-to-send command strobe |
| rtsMask | input | 3 | Buffers targeted by the command |
| reqPinN | input | 3 | Asynchronous active-low request pins |
| oneShot | input | 1 | One-shot mode enable |
| txStart | input | 1 | Engine starts an attempt on `nextBuf` |
| evtValid | input | 1 | Engine reports the end of an attempt |
| evtKind | input | 2 | 0 success, 1 error, 2 arbitration lost, 3 none |
| abortIn | input | 1 | Withdraw all pending buffers not in flight |
| intEn | input | 4 | Interrupt enables (bit 3 message error) |
| flagClrEn | input | 1 | Interrupt-flag clear strobe |
| flagClrMask | input | 4 | Flags to clear (bit 3 message error) |
| reqOut | output | 3 | Request bits |
| prioOut | output | 6 | Priorities, buffer i at bits [2i+1:2i] |
| abortFlag | output | 3 | Aborted flags |
| arbLostFlag | output | 3 | Arbitration-lost flags |
| txErrFlag | output | 3 | Transmit-error flags |
| txIntFlag | output | 3 | Transmit-complete interrupt flags |
| msgErrFlag | output | 1 | Global message-error flag |
| intN | output | 1 | Active-low interrupt |
| nextValid | output | 1 | A buffer is pending |
| nextBuf | output | 2 | Selected pending buffer |

## Verification
The assertions assume the engine pulses `txStart` only on a buffer that `nextValid` offers. They also assume it reports at most one outcome per attempt, and that `evtValid` never arrives in the same cycle as `abortIn` for the in-flight buffer. The stimulus follows these rules: every attempt starts with a single `txStart` pulse and ends with exactly one event before the next attempt. Abort and start are never driven in the same cycle. Writes, commands and pin edges are driven half a clock away from the sampling edge, and each scenario holds only one of them at a time.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  parameter int PRIO_W  = 2;
  parameter int CTRL_W  = 8;
  parameter int REQ_BIT = 3;

  typedef enum logic [1:0] {
    EVT_DONE = 2'd0,
    EVT_ERR  = 2'd1,
    EVT_LOST = 2'd2,
    EVT_NONE = 2'd3
  } evtKind_t;

  typedef struct packed {
    logic              setReq;
    logic              clrReq;
    logic              wrPrio;
    logic [PRIO_W-1:0] prioVal;
    logic              setAbort;
    logic              setArb;
    logic              setErr;
    logic              setTxIf;
    logic              clrTxIf;
  } bufStrobe_t;
endpackage

// File: rtl/can_tx_pin_sync.sv
module can_tx_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinN,
  output logic [WIDTH-1:0] fallPulse
);
  logic [WIDTH-1:0] stageQ [STAGES];
  logic [WIDTH-1:0] lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '1;
      lastQ <= '1;
    end else begin
      stageQ[0] <= pinN;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
      lastQ <= stageQ[STAGES-1];
    end
  end

  assign fallPulse = lastQ & ~stageQ[STAGES-1];

  // R4: an edge yields a single pulse, never a level
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fallPulse != '0) |=> ((fallPulse & $past(fallPulse)) == '0));
endmodule

// File: rtl/can_tx_ctrl.sv
module can_tx_ctrl
  import can_tx_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int BUF_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [BUF_W-1:0]  regWrBuf,
  input  logic [CTRL_W-1:0] regWrData,
  input  logic              rtsEn,
  input  logic [NUM_BUF-1:0] rtsMask,
  input  logic [NUM_BUF-1:0] pinFall,
  input  logic              oneShot,
  input  logic              txStart,
  input  logic              evtValid,
  input  logic [1:0]        evtKind,
  input  logic              abortIn,
  input  logic              flagClrEn,
  input  logic [NUM_BUF:0]  flagClrMask,
  input  logic [NUM_BUF-1:0] reqQ,
  input  logic              nextValid,
  input  logic [BUF_W-1:0]  nextBuf,
  output bufStrobe_t        stb [NUM_BUF],
  output logic              setMsgErr,
  output logic              clrMsgErr
);
  logic             inFlight;
  logic [BUF_W-1:0] flightBuf;
  logic             startOk;
  logic             evtLive;
  evtKind_t         kind;
  logic [NUM_BUF-1:0] isFly;

  assign kind    = evtKind_t'(evtKind);
  assign startOk = txStart && !inFlight && nextValid && !abortIn;
  assign evtLive = evtValid && inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight  <= 1'b0;
      flightBuf <= '0;
    end else if (startOk) begin
      inFlight  <= 1'b1;
      flightBuf <= nextBuf;
    end else if (evtLive) begin
      inFlight  <= 1'b0;
    end
  end

  assign setMsgErr = evtLive && (kind == EVT_ERR);
  assign clrMsgErr = flagClrEn && flagClrMask[NUM_BUF];

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic wrHit;
    logic fail;

    assign isFly[i] = inFlight && (flightBuf == BUF_W'(i));
    assign wrHit    = regWrEn && (regWrBuf == BUF_W'(i)) && !reqQ[i] && !isFly[i];
    assign fail     = evtLive && isFly[i] && ((kind == EVT_ERR) || (kind == EVT_LOST));

    always_comb begin
      stb[i]          = '0;
      stb[i].wrPrio   = wrHit;
      stb[i].prioVal  = regWrData[PRIO_W-1:0];
      stb[i].setReq   = !isFly[i] &&
                        ((wrHit && regWrData[REQ_BIT]) || (rtsEn && rtsMask[i]) || pinFall[i]);
      stb[i].setAbort = abortIn && reqQ[i] && !isFly[i];
      stb[i].setErr   = evtLive && isFly[i] && (kind == EVT_ERR);
      stb[i].setArb   = evtLive && isFly[i] && (kind == EVT_LOST);
      stb[i].setTxIf  = evtLive && isFly[i] && (kind == EVT_DONE);
      stb[i].clrTxIf  = flagClrEn && flagClrMask[i];
      stb[i].clrReq   = stb[i].setAbort || stb[i].setTxIf || (fail && oneShot);
    end

    // R7: the buffer in flight always still has its request pending
    assert_flight_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
      isFly[i] |-> reqQ[i]);

    // R8: success drops the request
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
      (evtValid && isFly[i] && kind == EVT_DONE) |=> !reqQ[i]);

    // R9: an error keeps the request for a retry outside one-shot mode
    assert_err_retry_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!oneShot && evtValid && isFly[i] && kind == EVT_ERR) |=> reqQ[i]);

    // R11: one-shot failure leaves nothing pending
    assert_single_shot_R11: assert property (@(posedge clk) disable iff (!rstN)
      (oneShot && evtValid && isFly[i] && (kind == EVT_ERR || kind == EVT_LOST)) |=> !reqQ[i]);

    // R12: abort spares the buffer being sent
    assert_abort_spares_R12: assert property (@(posedge clk) disable iff (!rstN)
      (abortIn && isFly[i] && !evtValid) |=> reqQ[i]);
  end
endmodule

// File: rtl/can_tx_datapath.sv
module can_tx_datapath
  import can_tx_pkg::*;
#(
  parameter int NUM_BUF = 3,
  parameter int BUF_W   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bufStrobe_t                stb [NUM_BUF],
  input  logic                      setMsgErr,
  input  logic                      clrMsgErr,
  input  logic [NUM_BUF:0]          intEn,
  output logic [NUM_BUF-1:0]        reqQ,
  output logic [NUM_BUF*PRIO_W-1:0] prioFlat,
  output logic [NUM_BUF-1:0]        abortQ,
  output logic [NUM_BUF-1:0]        arbQ,
  output logic [NUM_BUF-1:0]        errQ,
  output logic [NUM_BUF-1:0]        txIfQ,
  output logic                      msgErrQ,
  output logic                      intN,
  output logic                      nextValid,
  output logic [BUF_W-1:0]          nextBuf
);
  logic [PRIO_W-1:0] prioQ [NUM_BUF];

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ[i]   <= 1'b0;
        prioQ[i]  <= '0;
        abortQ[i] <= 1'b0;
        arbQ[i]   <= 1'b0;
        errQ[i]   <= 1'b0;
        txIfQ[i]  <= 1'b0;
      end else begin
        if (stb[i].setReq)      reqQ[i] <= 1'b1;
        else if (stb[i].clrReq) reqQ[i] <= 1'b0;
        if (stb[i].wrPrio) prioQ[i] <= stb[i].prioVal;
        if (stb[i].setReq) begin
          abortQ[i] <= 1'b0;
          arbQ[i]   <= 1'b0;
          errQ[i]   <= 1'b0;
        end else begin
          if (stb[i].setAbort) abortQ[i] <= 1'b1;
          if (stb[i].setArb)   arbQ[i]   <= 1'b1;
          if (stb[i].setErr)   errQ[i]   <= 1'b1;
        end
        if (stb[i].setTxIf)      txIfQ[i] <= 1'b1;
        else if (stb[i].clrTxIf) txIfQ[i] <= 1'b0;
      end
    end

    assign prioFlat[i*PRIO_W +: PRIO_W] = prioQ[i];

    // R5: a new request starts with clean failure flags
    assert_set_clears_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].setReq |=> (!abortQ[i] && !arbQ[i] && !errQ[i]));

    // R6: the selection always names a pending buffer
    assert_pick_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
      (nextValid && nextBuf == BUF_W'(i)) |-> reqQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          msgErrQ <= 1'b0;
    else if (setMsgErr) msgErrQ <= 1'b1;
    else if (clrMsgErr) msgErrQ <= 1'b0;
  end

  always_comb begin
    logic [PRIO_W-1:0] bestPrio;
    nextValid = 1'b0;
    nextBuf   = '0;
    bestPrio  = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (reqQ[i] && (!nextValid || prioQ[i] >= bestPrio)) begin
        nextValid = 1'b1;
        nextBuf   = BUF_W'(i);
        bestPrio  = prioQ[i];
      end
    end
  end

  assign intN = ~(|({msgErrQ, txIfQ} & intEn));

  // R13: a message-error flag survives until a clear arrives
  assert_flag_sticky_R13: assert property (@(posedge clk) disable iff (!rstN)
    ($past(msgErrQ) && !$past(clrMsgErr)) |-> msgErrQ);
endmodule

// File: rtl/can_tx_buf_ctrl.sv
module can_tx_buf_ctrl
  import can_tx_pkg::*;
#(
  parameter int NUM_BUF = 3,
  localparam int BUF_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regWrEn,
  input  logic [BUF_W-1:0]          regWrBuf,
  input  logic [CTRL_W-1:0]         regWrData,
  input  logic                      rtsEn,
  input  logic [NUM_BUF-1:0]        rtsMask,
  input  logic [NUM_BUF-1:0]        reqPinN,
  input  logic                      oneShot,
  input  logic                      txStart,
  input  logic                      evtValid,
  input  logic [1:0]                evtKind,
  input  logic                      abortIn,
  input  logic [NUM_BUF:0]          intEn,
  input  logic                      flagClrEn,
  input  logic [NUM_BUF:0]          flagClrMask,
  output logic [NUM_BUF-1:0]        reqOut,
  output logic [NUM_BUF*PRIO_W-1:0] prioOut,
  output logic [NUM_BUF-1:0]        abortFlag,
  output logic [NUM_BUF-1:0]        arbLostFlag,
  output logic [NUM_BUF-1:0]        txErrFlag,
  output logic [NUM_BUF-1:0]        txIntFlag,
  output logic                      msgErrFlag,
  output logic                      intN,
  output logic                      nextValid,
  output logic [BUF_W-1:0]          nextBuf
);
  bufStrobe_t         stb [NUM_BUF];
  logic [NUM_BUF-1:0] pinFall;
  logic               setMsgErr;
  logic               clrMsgErr;

  can_tx_pin_sync #(.WIDTH(NUM_BUF), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .pinN(reqPinN), .fallPulse(pinFall)
  );

  can_tx_ctrl #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrBuf(regWrBuf),
    .regWrData(regWrData), .rtsEn(rtsEn), .rtsMask(rtsMask), .pinFall(pinFall),
    .oneShot(oneShot), .txStart(txStart), .evtValid(evtValid), .evtKind(evtKind),
    .abortIn(abortIn), .flagClrEn(flagClrEn), .flagClrMask(flagClrMask),
    .reqQ(reqOut), .nextValid(nextValid), .nextBuf(nextBuf), .stb(stb),
    .setMsgErr(setMsgErr), .clrMsgErr(clrMsgErr)
  );

  can_tx_datapath #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .setMsgErr(setMsgErr), .clrMsgErr(clrMsgErr),
    .intEn(intEn), .reqQ(reqOut), .prioFlat(prioOut), .abortQ(abortFlag),
    .arbQ(arbLostFlag), .errQ(txErrFlag), .txIfQ(txIntFlag), .msgErrQ(msgErrFlag),
    .intN(intN), .nextValid(nextValid), .nextBuf(nextBuf)
  );
endmodule

// File: tb/can_tx_buf_ctrl_tb.sv
module can_tx_buf_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 0;
  logic [1:0] regWrBuf = 0;
  logic [7:0] regWrData = 0;
  logic       rtsEn = 0;
  logic [2:0] rtsMask = 0;
  logic [2:0] reqPinN = 3'b111;
  logic       oneShot = 0;
  logic       txStart = 0;
  logic       evtValid = 0;
  logic [1:0] evtKind = 0;
  logic       abortIn = 0;
  logic [3:0] intEn = 0;
  logic       flagClrEn = 0;
  logic [3:0] flagClrMask = 0;
  logic [2:0] reqOut, abortFlag, arbLostFlag, txErrFlag, txIntFlag;
  logic [5:0] prioOut;
  logic       msgErrFlag, intN, nextValid;
  logic [1:0] nextBuf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  can_tx_buf_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrBuf(regWrBuf), .regWrData(regWrData),
    .rtsEn(rtsEn), .rtsMask(rtsMask), .reqPinN(reqPinN), .oneShot(oneShot),
    .txStart(txStart), .evtValid(evtValid), .evtKind(evtKind), .abortIn(abortIn),
    .intEn(intEn), .flagClrEn(flagClrEn), .flagClrMask(flagClrMask), .reqOut(reqOut),
    .prioOut(prioOut), .abortFlag(abortFlag), .arbLostFlag(arbLostFlag),
    .txErrFlag(txErrFlag), .txIntFlag(txIntFlag), .msgErrFlag(msgErrFlag),
    .intN(intN), .nextValid(nextValid), .nextBuf(nextBuf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [1:0] b, input logic [7:0] d);
    @(negedge clk); regWrEn = 1; regWrBuf = b; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rts(input logic [2:0] m);
    @(negedge clk); rtsEn = 1; rtsMask = m;
    @(negedge clk); rtsEn = 0;
  endtask

  task automatic startTx();
    @(negedge clk); txStart = 1;
    @(negedge clk); txStart = 0;
  endtask

  task automatic event_(input logic [1:0] k);
    @(negedge clk); evtValid = 1; evtKind = k;
    @(negedge clk); evtValid = 0;
  endtask

  task automatic clrFlags(input logic [3:0] m);
    @(negedge clk); flagClrEn = 1; flagClrMask = m;
    @(negedge clk); flagClrEn = 0;
  endtask

  task automatic t_reset();
    chk("R1 req", reqOut, 0);
    chk("R1 prio", prioOut, 0);
    chk("R1 flags", {abortFlag, arbLostFlag, txErrFlag, txIntFlag, msgErrFlag}, 0);
    chk("R1 intN", intN, 1);
    chk("R1 nextValid", nextValid, 0);
  endtask

  task automatic t_write();
    wrCtrl(2'd0, 8'h0A);
    chk("R2 req0 set", reqOut[0], 1);
    chk("R2 prio0", prioOut[1:0], 2);
    wrCtrl(2'd0, 8'h03);
    chk("R2 write while pending ignored", prioOut[1:0], 2);
    wrCtrl(2'd1, 8'h0A);
    wrCtrl(2'd2, 8'h09);
    chk("R2 req all", reqOut, 3'b111);
  endtask

  task automatic t_select();
    chk("R6 valid", nextValid, 1);
    chk("R6 tie to higher index", nextBuf, 1);
  endtask

  task automatic t_success();
    startTx();
    startTx(); // R7 second start ignored while in flight
    event_(2'd0);
    chk("R8 req", reqOut, 3'b101);
    chk("R8 txIf", txIntFlag, 3'b010);
    chk("R13 masked intN", intN, 1);
    @(negedge clk); intEn = 4'b0010;
    @(negedge clk);
    chk("R13 enabled intN", intN, 0);
    clrFlags(4'b0010);
    chk("R13 cleared flag", txIntFlag, 0);
    chk("R13 intN released", intN, 1);
    intEn = 0;
  endtask

  task automatic t_error();
    chk("R6 highest prio", nextBuf, 0);
    startTx();
    event_(2'd1);
    chk("R9 req kept", reqOut[0], 1);
    chk("R9 txErr", txErrFlag, 3'b001);
    chk("R9 msgErr", msgErrFlag, 1);
    @(negedge clk); intEn = 4'b1000;
    @(negedge clk);
    chk("R13 msgErr intN", intN, 0);
    clrFlags(4'b1000);
    chk("R13 msgErr cleared", msgErrFlag, 0);
    intEn = 0;
  endtask

  task automatic t_rts();
    rts(3'b001);
    chk("R5 err cleared", txErrFlag, 0);
    rts(3'b010);
    chk("R3 req1", reqOut, 3'b111);
    chk("R6 after rts", nextBuf, 1);
  endtask

  task automatic t_arb();
    startTx();
    event_(2'd2);
    chk("R10 arb", arbLostFlag, 3'b010);
    chk("R10 req kept", reqOut, 3'b111);
    startTx();
    event_(2'd3);
    chk("R10 kind3 no change", {reqOut, arbLostFlag, txErrFlag, txIntFlag}, {3'b111, 3'b010, 3'b000, 3'b000});
  endtask

  task automatic t_oneshot();
    oneShot = 1;
    startTx();
    event_(2'd2);
    chk("R11 lost req cleared", reqOut, 3'b101);
    chk("R11 lost flag", arbLostFlag, 3'b010);
    startTx();
    event_(2'd1);
    chk("R11 err req cleared", reqOut, 3'b100);
    chk("R11 err flag", txErrFlag, 3'b001);
    oneShot = 0;
    clrFlags(4'b1000);
  endtask

  task automatic t_abort();
    rts(3'b001);
    startTx();
    @(negedge clk); abortIn = 1;
    @(negedge clk); abortIn = 0;
    chk("R12 req", reqOut, 3'b001);
    chk("R12 abort flag", abortFlag, 3'b100);
    event_(2'd0);
    chk("R8 buf0 done", {reqOut, txIntFlag}, {3'b000, 3'b001});
  endtask

  task automatic t_pin();
    @(negedge clk); reqPinN[2] = 0;
    @(negedge clk); chk("R4 not yet 1", reqOut[2], 0);
    @(negedge clk); chk("R4 not yet 2", reqOut[2], 0);
    @(negedge clk); chk("R4 set", reqOut[2], 1);
    chk("R5 abort cleared", abortFlag, 0);
    startTx();
    event_(2'd0);
    repeat (4) @(negedge clk);
    chk("R4 held low no reset", reqOut[2], 0);
    reqPinN[2] = 1;
  endtask

  task automatic t_idle();
    chk("R6 none pending", nextValid, 0);
    startTx();
    event_(2'd0);
    chk("R7 idle start ignored", {reqOut, txIntFlag}, {3'b000, 3'b101});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_select();
    t_success();
    t_error();
    t_rts();
    t_arb();
    t_oneshot();
    t_abort();
    t_pin();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule